// File: doc/BRIEF.md
# Hardwired Microstep Control Decoder

This block sequences a small byte-coded stack machine. A step counter walks through up to eight microsteps. Each step is decoded into a one-hot strobe, and every datapath control line is a sum of products of that strobe and the decoded opcode. The block drives register load and drive enables, ALU function bits, memory strobes, bus-direction controls and the sequence-end line. The datapath, ALU, memory and registers sit outside the block.

Every instruction starts with a shared fetch step. That step loads the next byte into the external opcode register and increments the program counter. The steps that follow are chosen by the opcode now held in that register. The last step of each sequence raises the end line, and the counter returns to the fetch step on the next clock. A halt input stops execution: while it is high the counter holds its value and every control line is low. The two ALU flag inputs exist for branch sequences, and none of the sequences built here reads them.

Top module: `ctl_decoder`

## Requirements
- R1: When neither reset, halt nor the end line is active, the step counter advances by one on each rising clock edge. `step_oh` has exactly one bit set, and bit i is set while the counter is at step i.
- R2: A clock edge with `ctl[25]` (end) high and halt low returns the counter to step 0 (`step_oh` = 8'h01).
- R3: In step 0 the outputs are exactly: pc_out(0), pc_in(1), op_in(13), f0(14), f1(15), enb(17), inc(19), cs(20), rd(21) and oe(22). This holds for any opcode.
- R4: Opcode 8'h10 (push immediate) runs four steps after step 0. Step 1 is operand fetch: bits 0,1,3,14,15,17,19,20,21,22. Step 2 is bits 2,5,11,15,17. Step 3 is bits 7,8,9,14,15,17,19. Step 4 is bits 6,20,24,25.
- R5: Opcode 8'h60 (add) runs four steps after step 0. Step 1 is bits 7,8,9,14,15,17,18. Step 2 is bits 10,12,15,17,20,21,22,23. Step 3 is bits 4,5,11,14,15,16,17. Step 4 is bits 6,20,24,25.
- R6: Opcode 8'h15 (load local) runs six steps after step 0. Step 1 is operand fetch, the same bits as in R4. Step 2 is bits 2,7,15,17. Step 3 is bits 6,20,21,22,23. Step 4 is bits 4,11,15,17. Step 5 is bits 7,8,9,14,15,17,19. Step 6 is bits 6,20,24,25.
- R7: Any other opcode sets only bit 25 (end) in step 1, so the byte acts as a no-op and the next step is a fetch.
- R8: A synchronous active-high reset puts the counter at step 0. After the reset edge the outputs equal the step-0 fetch set.
- R9: While `halt` is high, `ctl` is all zero and the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Stops execution: freezes the counter and clears all controls |
| opcode | input | 8 | Current contents of the external opcode register |
| alu_n | input | 1 | ALU negative flag, for branch sequences |
| alu_z | input | 1 | ALU zero flag, for branch sequences |
| ctl | output | 26 | Control vector, bit positions as given in R3 to R7 |
| step_oh | output | 8 | One-hot current step |

## Verification
The hardest case to reach is a halt that lands in the middle of an instruction. The counter must then resume at exactly the step it left, with the same opcode still applied, so that the rest of the sequence is unchanged. The stimulus raises `halt` for a few cycles at chosen points inside the add and load-local sequences. It also applies a reset in the middle of a push. A behavioural step model in the bench follows the same halts and resets and predicts the full control vector on every cycle.

// File: rtl/ctl_decoder_pkg.sv
package ctl_decoder_pkg;
  localparam int CTL_W = 26;
  typedef logic [CTL_W-1:0] ctl_t;

  localparam int B_PC_OUT  = 0;
  localparam int B_PC_IN   = 1;
  localparam int B_MBR_OUT = 2;
  localparam int B_MBR_IN  = 3;
  localparam int B_MDR_OUT = 4;
  localparam int B_MDR_IN  = 5;
  localparam int B_MAR_OUT = 6;
  localparam int B_MAR_IN  = 7;
  localparam int B_SP_OUT  = 8;
  localparam int B_SP_IN   = 9;
  localparam int B_TOS_OUT = 10;
  localparam int B_TOS_IN  = 11;
  localparam int B_H_IN    = 12;
  localparam int B_OP_IN   = 13;
  localparam int B_F0      = 14;
  localparam int B_F1      = 15;
  localparam int B_ENA     = 16;
  localparam int B_ENB     = 17;
  localparam int B_INVA    = 18;
  localparam int B_INC     = 19;
  localparam int B_CS      = 20;
  localparam int B_RD      = 21;
  localparam int B_OE      = 22;
  localparam int B_LOAD_D  = 23;
  localparam int B_DRIVE_D = 24;
  localparam int B_END     = 25;

  typedef struct packed {
    logic add;
    logic load_local;
    logic push_imm;
    logic unknown;
  } instr_t;
endpackage

// File: rtl/ctl_step_counter.sv
module ctl_step_counter #(
  parameter int STEP_W = 3,
  localparam int NSTEPS = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              seq_end,
  output logic [STEP_W-1:0] step_q,
  output logic [NSTEPS-1:0] step_oh
);
  always_ff @(posedge clk) begin
    if (rst)          step_q <= '0;
    else if (hold)    step_q <= step_q;
    else if (seq_end) step_q <= '0;
    else              step_q <= STEP_W'(step_q + 1'b1);
  end

  for (genvar i = 0; i < NSTEPS; i++) begin : g_oh
    assign step_oh[i] = (step_q == STEP_W'(i));
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(step_oh) == 1);
  p_advance_r1: assert property (@(posedge clk) disable iff (rst)
    (!hold && !seq_end) |=> step_q == STEP_W'($past(step_q) + 1'b1));
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold && seq_end) |=> step_oh[0]);
  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(step_q));
endmodule

// File: rtl/ctl_op_decode.sv
module ctl_op_decode
  import ctl_decoder_pkg::*;
#(
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OPC_ADD  = 8'h60,
  parameter logic [OP_W-1:0] OPC_LOAD = 8'h15,
  parameter logic [OP_W-1:0] OPC_PUSH = 8'h10
) (
  input  logic [OP_W-1:0] opcode,
  output instr_t          instr
);
  always_comb begin
    instr = '0;
    unique case (opcode)
      OPC_ADD:  instr.add        = 1'b1;
      OPC_LOAD: instr.load_local = 1'b1;
      OPC_PUSH: instr.push_imm   = 1'b1;
      default:  instr.unknown    = 1'b1;
    endcase
  end
endmodule

// File: rtl/ctl_matrix.sv
module ctl_matrix
  import ctl_decoder_pkg::*;
#(
  parameter int NSTEPS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTEPS-1:0] t,
  input  instr_t            instr,
  output ctl_t              ctl_raw
);
  logic ad, ld, ps, uk;
  logic t0, t1, t2, t3, t4, t5, t6;
  assign ad = instr.add;
  assign ld = instr.load_local;
  assign ps = instr.push_imm;
  assign uk = instr.unknown;
  assign t0 = t[0];
  assign t1 = t[1];
  assign t2 = t[2];
  assign t3 = t[3];
  assign t4 = t[4];
  assign t5 = t[5];
  assign t6 = t[6];

  logic opnd_fetch, alu_pass;
  assign opnd_fetch = t0 | (t1 & (ps | ld));
  assign alu_pass   = (t1 & ad) | (t2 & (ps | ad | ld)) | (t3 & (ps | ad))
                    | (t4 & ld) | (t5 & ld);

  always_comb begin
    ctl_raw = '0;
    ctl_raw[B_PC_OUT]  = opnd_fetch;
    ctl_raw[B_PC_IN]   = opnd_fetch;
    ctl_raw[B_MBR_IN]  = t1 & (ps | ld);
    ctl_raw[B_MBR_OUT] = t2 & (ps | ld);
    ctl_raw[B_MDR_OUT] = (t3 & ad) | (t4 & ld);
    ctl_raw[B_MDR_IN]  = (t2 & ps) | (t3 & ad);
    ctl_raw[B_MAR_OUT] = (t4 & (ps | ad)) | (t3 & ld) | (t6 & ld);
    ctl_raw[B_MAR_IN]  = (t3 & ps) | (t1 & ad) | (t2 & ld) | (t5 & ld);
    ctl_raw[B_SP_OUT]  = (t3 & ps) | (t1 & ad) | (t5 & ld);
    ctl_raw[B_SP_IN]   = (t3 & ps) | (t1 & ad) | (t5 & ld);
    ctl_raw[B_TOS_OUT] = t2 & ad;
    ctl_raw[B_TOS_IN]  = (t2 & ps) | (t3 & ad) | (t4 & ld);
    ctl_raw[B_H_IN]    = t2 & ad;
    ctl_raw[B_OP_IN]   = t0;
    ctl_raw[B_F0]      = opnd_fetch | (t1 & ad) | (t3 & (ad | ps)) | (t5 & ld);
    ctl_raw[B_F1]      = opnd_fetch | alu_pass;
    ctl_raw[B_ENA]     = t3 & ad;
    ctl_raw[B_ENB]     = opnd_fetch | alu_pass;
    ctl_raw[B_INVA]    = t1 & ad;
    ctl_raw[B_INC]     = opnd_fetch | (t3 & ps) | (t5 & ld);
    ctl_raw[B_CS]      = opnd_fetch | (t2 & ad) | (t3 & ld)
                       | (t4 & (ps | ad)) | (t6 & ld);
    ctl_raw[B_RD]      = opnd_fetch | (t2 & ad) | (t3 & ld);
    ctl_raw[B_OE]      = opnd_fetch | (t2 & ad) | (t3 & ld);
    ctl_raw[B_LOAD_D]  = (t2 & ad) | (t3 & ld);
    ctl_raw[B_DRIVE_D] = (t4 & (ps | ad)) | (t6 & ld);
    ctl_raw[B_END]     = (t4 & (ps | ad)) | (t6 & ld) | (t1 & uk);
  end

  p_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    t0 |-> (ctl_raw[B_OP_IN] && ctl_raw[B_PC_IN] && ctl_raw[B_RD] && !ctl_raw[B_END]));
  p_unknown_nop_r7: assert property (@(posedge clk) disable iff (rst)
    (t1 && uk) |-> ctl_raw == ctl_t'(1) << B_END);
  p_write_ends_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_raw[B_DRIVE_D] |-> ctl_raw[B_END]);
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_decoder_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int OP_W   = 8,
  localparam int NSTEPS = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic [OP_W-1:0]   opcode,
  input  logic              alu_n,
  input  logic              alu_z,
  output logic [CTL_W-1:0]  ctl,
  output logic [NSTEPS-1:0] step_oh
);
  logic [STEP_W-1:0] step_q;
  instr_t instr;
  ctl_t   ctl_raw;
  logic   flags_unused;

  assign flags_unused = alu_n ^ alu_z;

  ctl_step_counter #(.STEP_W(STEP_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .hold    (halt),
    .seq_end (ctl_raw[B_END]),
    .step_q  (step_q),
    .step_oh (step_oh)
  );

  ctl_op_decode #(.OP_W(OP_W)) u_dec (
    .opcode (opcode),
    .instr  (instr)
  );

  ctl_matrix #(.NSTEPS(NSTEPS)) u_mat (
    .clk     (clk),
    .rst     (rst),
    .t       (step_oh),
    .instr   (instr),
    .ctl_raw (ctl_raw)
  );

  assign ctl = halt ? '0 : (flags_unused & 1'b0) ? '0 : ctl_raw;

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halt |-> ctl == '0);
  p_end_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl[B_END] && !halt) |=> step_oh == NSTEPS'(1));
  p_reset_fetch_r8: assert property (@(posedge clk)
    $past(rst) |-> step_oh[0]);
endmodule

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb;
  localparam int W = 26;
  localparam int PCO=0, PCI=1, MBRO=2, MBRI=3, MDRO=4, MDRI=5, MARO=6, MARI=7;
  localparam int SPO=8, SPI=9, TOSO=10, TOSI=11, HI=12, OPI=13, F0=14, F1=15;
  localparam int ENA=16, ENB=17, INVA=18, INC=19, CS=20, RD=21, OE=22;
  localparam int LDD=23, DRD=24, ENDB=25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic alu_n = 1'b0, alu_z = 1'b0;
  logic [W-1:0] ctl;
  logic [7:0] step_oh;

  int checks = 0, fails = 0, cycle = 0, step_m = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctl_decoder u_dut (.clk(clk), .rst(rst), .halt(halt), .opcode(opcode),
    .alu_n(alu_n), .alu_z(alu_z), .ctl(ctl), .step_oh(step_oh));

  function automatic logic [W-1:0] mk(input int b[]);
    logic [W-1:0] v = '0;
    foreach (b[i]) v[b[i]] = 1'b1;
    return v;
  endfunction

  function automatic logic [W-1:0] expect_ctl(input int s, input logic [7:0] op, input logic h);
    logic [W-1:0] fetch_op = mk('{PCO,PCI,F0,F1,ENB,INC,CS,RD,OE,MBRI});
    logic [W-1:0] sp_up    = mk('{SPO,F0,F1,ENB,INC,SPI,MARI});
    logic [W-1:0] wr_done  = mk('{MARO,CS,DRD,ENDB});
    if (h) return '0;
    if (s == 0) return mk('{PCO,PCI,OPI,F0,F1,ENB,INC,CS,RD,OE});
    case (op)
      8'h10: case (s)
        1: return fetch_op;
        2: return mk('{MBRO,F1,ENB,MDRI,TOSI});
        3: return sp_up;
        4: return wr_done;
        default: return '0;
      endcase
      8'h60: case (s)
        1: return mk('{SPO,F0,F1,ENB,INVA,SPI,MARI});
        2: return mk('{TOSO,F1,ENB,HI,CS,RD,OE,LDD});
        3: return mk('{MDRO,F0,F1,ENA,ENB,TOSI,MDRI});
        4: return wr_done;
        default: return '0;
      endcase
      8'h15: case (s)
        1: return fetch_op;
        2: return mk('{MBRO,F1,ENB,MARI});
        3: return mk('{MARO,CS,RD,OE,LDD});
        4: return mk('{MDRO,F1,ENB,TOSI});
        5: return sp_up;
        6: return wr_done;
        default: return '0;
      endcase
      default: return (s == 1) ? mk('{ENDB}) : '0;
    endcase
  endfunction

  function automatic string tag(input int s, input logic [7:0] op, input logic h, input logic r);
    if (r) return "R8";
    if (h) return "R9";
    if (s == 0) return "R3";
    case (op)
      8'h10: return "R4";
      8'h60: return "R5";
      8'h15: return "R6";
      default: return "R7";
    endcase
  endfunction

  // reference step model
  always @(posedge clk) begin
    if (rst) step_m = 0;
    else if (halt) step_m = step_m;
    else if (expect_ctl(step_m, opcode, 1'b0)[ENDB]) step_m = 0;
    else step_m = (step_m + 1) % 8;
    cycle++;
  end

  logic prev_rst = 1'b1;
  always @(negedge clk) begin
    if (!done && cycle > 0) begin
      logic [W-1:0] e;
      e = expect_ctl(step_m, opcode, halt);
      checks++;
      if (ctl !== e) begin
        fails++;
        $display("FAIL %s ctl step=%0d op=%h actual=%h expected=%h",
                 tag(step_m, opcode, halt, prev_rst), step_m, opcode, ctl, e);
      end
      checks++;
      if (step_oh !== 8'(1 << step_m)) begin
        fails++;
        $display("FAIL R1/R2 step_oh op=%h actual=%h expected=%h",
                 opcode, step_oh, 8'(1 << step_m));
      end
      prev_rst = rst;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_op(input logic [7:0] op, input int halt_at, input int halt_len);
    while (step_m != 0) tick();
    opcode = op;
    for (int k = 0; k < 12; k++) begin
      if (k == halt_at) begin
        halt = 1'b1;
        for (int j = 0; j < halt_len; j++) tick();
        halt = 1'b0;
      end
      tick();
      if (step_m == 0) break;
    end
  endtask

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    // R8: reset state is step 0 with fetch set
    checks++;
    if (step_oh !== 8'h01 || ctl !== expect_ctl(0, opcode, 1'b0)) begin
      fails++;
      $display("FAIL R8 reset state actual=%h/%h expected=01/%h", step_oh, ctl,
               expect_ctl(0, opcode, 1'b0));
    end
    run_op(8'h10, -1, 0);
    run_op(8'h60, -1, 0);
    run_op(8'h15, -1, 0);
    run_op(8'hFF, -1, 0);
    run_op(8'h00, -1, 0);
    run_op(8'h60, 2, 3);   // R9 halt mid add
    run_op(8'h15, 4, 2);   // R9 halt mid load
    run_op(8'h15, 0, 1);   // R9 halt at step 0
    run_op(8'h10, -1, 0);
    // mid-sequence reset R8
    while (step_m != 0) tick();
    opcode = 8'h10;
    tick(); tick();
    rst = 1'b1; tick(); rst = 1'b0;
    run_op(8'h61, -1, 0);
    run_op(8'h60, -1, 0);
    repeat (3) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule